// File: doc/BRIEF.md
# Secondary Interrupt Controller with Pass-Through Lines

This block collects 32 level-sensitive interrupt sources into one combined request for a primary interrupt controller. Every cycle it captures the source levels in a raw level register. Software selects which sources may contribute through an enable mask. The combined request is the OR of all sources that are both asserted and enabled, and it drives primary line 31.

A second, independent path forwards sources 21 to 30 one-for-one to the matching primary lines. A separate pass-through enable register controls this path. An enabled line follows its source. A line whose enable is cleared keeps the value it last drove.

Software reaches both registers through a plain 32-bit register bus: a byte address in a 4 KB window (the word index is the address divided by four), read and write strobes, write data, and read data returned one cycle after the read strobe.

Top module: `sec_irq_ctrl`

## Requirements
- R1: On each clock the raw level register captures `irq_src`. A read of word index 1 returns it.
- R2: Output `prim_irq[31]` is high exactly when some bit of (raw level AND enable mask) is set. A read of word index 0 returns that AND.
- R3: A read strobe returns its data on `bus_rdata` one cycle later. When no read was strobed in the previous cycle, `bus_rdata` is zero. A read returns register contents from before any write in the same cycle.
- R4: A write to word index 2 ORs the data into the enable mask. A write to word index 3 clears the mask bits where the data has ones. A read of word index 2 returns the mask.
- R5: A write of nonzero data to word index 4 sets mask bit 0, and a nonzero write to word index 5 clears it. A write of zero to either word has no effect. A read of word index 4 returns raw level bit 0 in bit 0, with all other bits zero.
- R6: A write to word index 8 ORs (data AND 0x7FE00000) into the pass-through enable, so only bits 21 to 30 can be set. A write to word index 9 clears the bits where the data has ones. A read of word index 8 returns the pass-through enable.
- R7: For each line i from 21 to 30 whose pass-through enable is set, `prim_irq[i]` equals raw level bit i. This holds from the cycle after the enable is written.
- R8: A pass-through line whose enable is clear holds the value it last drove. Lines 0 to 20 are always low.
- R9: Reads of word indices other than 0, 1, 2, 4 and 8 return zero. Writes to word indices other than 2, 3, 4, 5, 8 and 9 change no state.
- R10: A synchronous active-high reset clears the raw level, the enable mask, the pass-through enable and the held line values. All outputs are then low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Level-sensitive interrupt sources, synchronous to clk |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| prim_irq | output | 32 | Lines to the primary controller: 31 combined, 21 to 30 pass-through, others low |

## Verification
The sources are driven first with sparse fixed patterns, so that the masked status can be told apart from the raw level. Alternating bit patterns across lines 21 to 30 show whether each pass-through line follows its own source rather than a neighbour's. Enable writes with data spilling outside bits 21 to 30, zero-valued soft writes and writes to unused words show that only the intended bits move. A long pseudo-random mix of source changes, register writes and reads then runs against the reference model cycle by cycle. In that run, enable toggling while sources change separates holding behaviour from following behaviour.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

   // Word indices whose meaning the bus decode depends on
   localparam int unsigned WI_STATUS   = 0;
   localparam int unsigned WI_RAW      = 1;
   localparam int unsigned WI_MASK_SET = 2;
   localparam int unsigned WI_MASK_CLR = 3;
   localparam int unsigned WI_BIT0_SET = 4;
   localparam int unsigned WI_BIT0_CLR = 5;
   localparam int unsigned WI_PASS_SET = 8;
   localparam int unsigned WI_PASS_CLR = 9;

   typedef struct packed {
      logic mask_set;
      logic mask_clr;
      logic bit0_set;
      logic bit0_clr;
      logic pass_set;
      logic pass_clr;
   } wr_strobe_t;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_STATUS,
      RSEL_RAW,
      RSEL_MASK,
      RSEL_BIT0,
      RSEL_PASS
   } rd_sel_t;

endpackage

// File: rtl/sec_irq_decode.sv
module sec_irq_decode
   import sec_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output wr_strobe_t        wstb,
   output rd_sel_t           rsel
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             unused_lsb;

   assign idx        = addr[ADDR_W-1:2];
   assign unused_lsb = ^addr[1:0];

   always_comb begin
      wstb          = '0;
      wstb.mask_set = wr && (idx == IDX_W'(WI_MASK_SET));
      wstb.mask_clr = wr && (idx == IDX_W'(WI_MASK_CLR));
      wstb.bit0_set = wr && (idx == IDX_W'(WI_BIT0_SET));
      wstb.bit0_clr = wr && (idx == IDX_W'(WI_BIT0_CLR));
      wstb.pass_set = wr && (idx == IDX_W'(WI_PASS_SET));
      wstb.pass_clr = wr && (idx == IDX_W'(WI_PASS_CLR));
   end

   always_comb begin
      case (idx)
         IDX_W'(WI_STATUS):   rsel = RSEL_STATUS;
         IDX_W'(WI_RAW):      rsel = RSEL_RAW;
         IDX_W'(WI_MASK_SET): rsel = RSEL_MASK;
         IDX_W'(WI_BIT0_SET): rsel = RSEL_BIT0;
         IDX_W'(WI_PASS_SET): rsel = RSEL_PASS;
         default:             rsel = RSEL_NONE;
      endcase
   end

endmodule

// File: rtl/sec_irq_regs.sv
module sec_irq_regs
   import sec_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned PT_LO   = 21,
   parameter int unsigned PT_HI   = 30
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] irq_src,
   input  wr_strobe_t         wstb,
   input  rd_sel_t            rsel,
   input  logic               rd,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] level_q,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] pass_q,
   output logic [NUM_SRC-1:0] rdata_q
);
   function automatic logic [NUM_SRC-1:0] span_mask();
      logic [NUM_SRC-1:0] m;
      m = '0;
      for (int i = 0; i < int'(NUM_SRC); i++)
         if (i >= int'(PT_LO) && i <= int'(PT_HI)) m[i] = 1'b1;
      return m;
   endfunction

   localparam logic [NUM_SRC-1:0] PASS_MASK = span_mask();

   logic               wdata_nz;
   logic [NUM_SRC-1:0] mask_d;
   logic [NUM_SRC-1:0] pass_d;
   logic [NUM_SRC-1:0] rd_val;

   assign wdata_nz = |wdata;

   always_comb begin
      mask_d = mask_q;
      if (wstb.mask_set)             mask_d = mask_d | wdata;
      if (wstb.mask_clr)             mask_d = mask_d & ~wdata;
      if (wstb.bit0_set && wdata_nz) mask_d[0] = 1'b1;
      if (wstb.bit0_clr && wdata_nz) mask_d[0] = 1'b0;
   end

   always_comb begin
      pass_d = pass_q;
      if (wstb.pass_set) pass_d = pass_d | (wdata & PASS_MASK);
      if (wstb.pass_clr) pass_d = pass_d & ~wdata;
   end

   always_comb begin
      rd_val = '0;
      case (rsel)
         RSEL_STATUS: rd_val = level_q & mask_q;
         RSEL_RAW:    rd_val = level_q;
         RSEL_MASK:   rd_val = mask_q;
         RSEL_BIT0:   rd_val[0] = level_q[0];
         RSEL_PASS:   rd_val = pass_q;
         default:     rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= '0;
         mask_q  <= '0;
         pass_q  <= '0;
         rdata_q <= '0;
      end else begin
         level_q <= irq_src;
         mask_q  <= mask_d;
         pass_q  <= pass_d;
         rdata_q <= rd ? rd_val : '0;
      end
   end

   // R1
   level_capture_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> level_q == $past(irq_src));

   // R4
   mask_set_chk: assert property (@(posedge clk) disable iff (rst)
      wstb.mask_set |=> (mask_q & $past(wdata)) == $past(wdata));

   // R4
   mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
      wstb.mask_clr |=> (mask_q & $past(wdata)) == '0);

   // R6
   pass_range_chk: assert property (@(posedge clk) disable iff (rst)
      wstb.pass_set |=> (pass_q & ~PASS_MASK) == '0);

   // R9
   idle_write_chk: assert property (@(posedge clk) disable iff (rst)
      !(|wstb) |=> $stable(mask_q) && $stable(pass_q));

   // R3
   rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !rd |=> rdata_q == '0);

endmodule

// File: rtl/sec_irq_route.sv
module sec_irq_route #(
   parameter int unsigned NUM_SRC   = 32,
   parameter int unsigned PT_LO     = 21,
   parameter int unsigned PT_HI     = 30,
   parameter int unsigned COMB_LINE = 31
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] level,
   input  logic [NUM_SRC-1:0] mask,
   input  logic [NUM_SRC-1:0] pass_en,
   output logic [NUM_SRC-1:0] lines
);
   logic comb_req;
   logic unused_bits;

   assign comb_req    = |(level & mask);
   assign unused_bits = ^{level[PT_LO-1:0], pass_en[PT_LO-1:0],
                          level[NUM_SRC-1:PT_HI+1], pass_en[NUM_SRC-1:PT_HI+1]};

   for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_line
      if (i >= int'(PT_LO) && i <= int'(PT_HI)) begin : g_pass
         logic held_q;

         assign lines[i] = pass_en[i] ? level[i] : held_q;

         always_ff @(posedge clk) begin
            if (rst) held_q <= 1'b0;
            else     held_q <= lines[i];
         end

         // R8
         pass_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !pass_en[i] |=> pass_en[i] || $stable(lines[i]));
      end else if (i == int'(COMB_LINE)) begin : g_comb
         assign lines[i] = comb_req;
      end else begin : g_tie
         assign lines[i] = 1'b0;

         // R8
         tie_low_chk: assert property (@(posedge clk) disable iff (rst)
            lines[i] == 1'b0);
      end
   end

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
   import sec_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned PT_LO     = 21,
   parameter int unsigned PT_HI     = 30,
   parameter int unsigned COMB_LINE = 31
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] irq_src,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [NUM_SRC-1:0] bus_wdata,
   output logic [NUM_SRC-1:0] bus_rdata,
   output logic [NUM_SRC-1:0] prim_irq
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too small to reach word index 9");
   end
   if (PT_LO == 0 || PT_LO > PT_HI || PT_HI >= NUM_SRC - 1) begin : g_bad_span
      $error("pass-through span must sit strictly inside the source range");
   end
   if (COMB_LINE >= NUM_SRC || (COMB_LINE >= PT_LO && COMB_LINE <= PT_HI)) begin : g_bad_comb
      $error("combined line must be a valid line outside the pass-through span");
   end

   wr_strobe_t         wstb;
   rd_sel_t            rsel;
   logic [NUM_SRC-1:0] level_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] pass_q;

   sec_irq_decode #(.ADDR_W(ADDR_W)) decode_i (
      .addr (bus_addr),
      .wr   (bus_wr),
      .wstb (wstb),
      .rsel (rsel)
   );

   sec_irq_regs #(.NUM_SRC(NUM_SRC), .PT_LO(PT_LO), .PT_HI(PT_HI)) regs_i (
      .clk     (clk),
      .rst     (rst),
      .irq_src (irq_src),
      .wstb    (wstb),
      .rsel    (rsel),
      .rd      (bus_rd),
      .wdata   (bus_wdata),
      .level_q (level_q),
      .mask_q  (mask_q),
      .pass_q  (pass_q),
      .rdata_q (bus_rdata)
   );

   sec_irq_route #(.NUM_SRC(NUM_SRC), .PT_LO(PT_LO), .PT_HI(PT_HI),
                   .COMB_LINE(COMB_LINE)) route_i (
      .clk     (clk),
      .rst     (rst),
      .level   (level_q),
      .mask    (mask_q),
      .pass_en (pass_q),
      .lines   (prim_irq)
   );

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> prim_irq == '0 && bus_rdata == '0);

   // R2
   comb_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(prim_irq[COMB_LINE]) |-> $changed(level_q) || $changed(mask_q));

endmodule

// File: tb/sec_irq_ctrl_tb_top.sv
module sec_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] irq_src = '0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] prim_irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // Reference model state
   logic [31:0] m_level = '0, m_mask = '0, m_pass = '0, m_held = '0, m_rdata = '0;

   always #2 clk = ~clk;

   sec_irq_ctrl dut_i (
      .clk(clk), .rst(rst), .irq_src(irq_src), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .prim_irq(prim_irq)
   );

   function automatic logic [31:0] model_lines(logic [31:0] lv, logic [31:0] mk,
                                               logic [31:0] ps, logic [31:0] hd);
      logic [31:0] o;
      o = '0;
      for (int i = 21; i <= 30; i++) o[i] = ps[i] ? lv[i] : hd[i];
      o[31] = |(lv & mk);
      return o;
   endfunction

   function automatic logic [31:0] model_read(int idx);
      case (idx)
         0: return m_level & m_mask;
         1: return m_level;
         2: return m_mask;
         4: return {31'b0, m_level[0]};
         8: return m_pass;
         default: return '0;
      endcase
   endfunction

   always @(posedge clk) begin
      logic [31:0] out_now;
      int idx;
      idx = int'(bus_addr[11:2]);
      if (rst) begin
         m_level = '0; m_mask = '0; m_pass = '0; m_held = '0; m_rdata = '0;
      end else begin
         out_now = model_lines(m_level, m_mask, m_pass, m_held);
         m_rdata = bus_rd ? model_read(idx) : '0;
         m_held  = out_now;
         m_level = irq_src;
         if (bus_wr) begin
            case (idx)
               2: m_mask = m_mask | bus_wdata;
               3: m_mask = m_mask & ~bus_wdata;
               4: if (bus_wdata != 0) m_mask[0] = 1'b1;
               5: if (bus_wdata != 0) m_mask[0] = 1'b0;
               8: m_pass = m_pass | (bus_wdata & 32'h7FE0_0000);
               9: m_pass = m_pass & ~bus_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      logic [31:0] exp_l;
      if (!done) begin
         exp_l = model_lines(m_level, m_mask, m_pass, m_held);
         chk("R3 rdata vs model", bus_rdata, m_rdata);
         chk("R2 combined line", {31'b0, prim_irq[31]}, {31'b0, exp_l[31]});
         chk("R7 pass lines", prim_irq & 32'h7FE0_0000, exp_l & 32'h7FE0_0000);
         chk("R8 low lines", prim_irq & 32'h001F_FFFF, 32'h0);
      end
   end

   task automatic bus_write(int idx, logic [31:0] d);
      bus_addr = 12'(idx * 4); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(int idx, string tag, logic [31:0] exp);
      bus_addr = 12'(idx * 4); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      #1 chk(tag, bus_rdata, exp);
   endtask

   task automatic summary();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog R10 actual %0d expected below 100000", cycles);
         summary();
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R10 reset state
      chk("R10 lines after reset", prim_irq, 32'h0);
      chk("R10 rdata after reset", bus_rdata, 32'h0);
      @(negedge clk);

      // R1 raw level and R2 masked status with mask empty
      irq_src = 32'h0000_0011;
      @(negedge clk);
      bus_read(1, "R1 raw level", 32'h0000_0011);
      bus_read(0, "R2 status with empty mask", 32'h0);
      chk("R2 combined low", {31'b0, prim_irq[31]}, 32'h0);

      // R4 enable set / clear
      bus_write(2, 32'h0000_0010);
      bus_read(2, "R4 mask after set", 32'h0000_0010);
      bus_read(0, "R2 status after enable", 32'h0000_0010);
      chk("R2 combined high", {31'b0, prim_irq[31]}, 32'h1);
      bus_write(3, 32'h0000_0010);
      bus_read(2, "R4 mask after clear", 32'h0);
      chk("R2 combined low again", {31'b0, prim_irq[31]}, 32'h0);

      // R5 bit-0 words
      bus_write(4, 32'h0);
      bus_read(2, "R5 zero write to set word ignored", 32'h0);
      bus_write(4, 32'h0000_0005);
      bus_read(2, "R5 bit0 set", 32'h0000_0001);
      bus_read(4, "R5 bit0 read shows level bit0", 32'h0000_0001);
      chk("R5 combined from bit0", {31'b0, prim_irq[31]}, 32'h1);
      bus_write(5, 32'h0);
      bus_read(2, "R5 zero write to clear word ignored", 32'h0000_0001);
      bus_write(5, 32'h0000_0700);
      bus_read(2, "R5 bit0 cleared", 32'h0);

      // R6 pass-through enable
      bus_write(8, 32'hFFFF_FFFF);
      bus_read(8, "R6 pass enable limited", 32'h7FE0_0000);
      irq_src = 32'h2AA0_0000;
      @(negedge clk);
      chk("R7 pass lines follow alternating", prim_irq & 32'h7FE0_0000, 32'h2AA0_0000);
      irq_src = 32'h5540_0000;
      @(negedge clk);
      chk("R7 pass lines follow inverse", prim_irq & 32'h7FE0_0000, 32'h5540_0000);
      bus_write(9, 32'h0040_0000);
      bus_read(8, "R6 pass enable after clear", 32'h7FA0_0000);
      // R8 line 22 holds its last value (1) while source drops
      irq_src = 32'hFFFF_FFFF & ~32'h0040_0000;
      @(negedge clk);
      chk("R8 disabled line holds", {31'b0, prim_irq[22]}, 32'h1);
      chk("R8 lines 0..20 low", prim_irq & 32'h001F_FFFF, 32'h0);

      // R9 undefined offsets
      bus_write(6, 32'hFFFF_FFFF);
      bus_write(7, 32'hFFFF_FFFF);
      bus_write(10, 32'hFFFF_FFFF);
      bus_write(1023, 32'hFFFF_FFFF);
      bus_read(2, "R9 mask unchanged", 32'h0);
      bus_read(8, "R9 pass unchanged", 32'h7FA0_0000);
      bus_read(3, "R9 read word3", 32'h0);
      bus_read(5, "R9 read word5", 32'h0);
      bus_read(9, "R9 read word9", 32'h0);
      bus_read(1023, "R9 read last word", 32'h0);

      // Pseudo-random mix compared against the model every cycle
      lfsr = 32'hACE1_2345;
      for (int n = 0; n < 2000; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         irq_src   = lfsr ^ {lfsr[15:0], lfsr[31:16]};
         bus_addr  = {lfsr[7:4] , 2'b00} ;
         bus_wdata = {lfsr[9:0], lfsr[31:10]};
         bus_wr    = lfsr[12];
         bus_rd    = lfsr[13];
         @(negedge clk);
      end
      bus_wr = 1'b0; bus_rd = 1'b0;

      // R10 reset in the middle of activity
      bus_write(2, 32'hFFFF_FFFF);
      bus_write(8, 32'hFFFF_FFFF);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      irq_src = '0;
      #1 chk("R10 lines cleared by reset", prim_irq, 32'h0);
      bus_read(2, "R10 mask cleared", 32'h0);
      bus_read(8, "R10 pass cleared", 32'h0);

      summary();
   end

endmodule